// File: doc/BRIEF.md
# Dual-Clock FIFO with First-Word Fall-Through

This block moves data words from a write clock domain to an unrelated read clock domain. Each side keeps its own binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other domain through a two-flop synchronizer. The write side uses the far pointer to raise a full flag. The read side uses it to learn that stored words exist. Both enables are active low. A master reset clears both domains at once.

A static mode input selects how reads behave. In standard mode, the read-side status pin is an empty flag, active low. A read strobe taken while that flag is high moves the next word onto the output register at that read clock edge. In fall-through mode, the same pin is an output-ready flag, active low. The first stored word is loaded into an output holding register without any read strobe. The flag drops low at the edge where that word appears. A read strobe consumes the word that is on the bus. Because the holding register acts as one more slot, the block holds one word more in this mode than in standard mode. The mode may change only while reset is held.

Top module: `dual_clock_fifo`

## Requirements
- R1: While and after master reset (`mrst_n` low), `full` is 0 and `rd_data` is all zeros. `rd_stat_n` is 0 in standard mode (`fwft_mode`=0) and 1 in fall-through mode (`fwft_mode`=1).
- R2: In both modes, every accepted word leaves the read port exactly once, in write order, with no word lost or duplicated.
- R3: With no reads, the block accepts 2^ADDR_W words in standard mode and 2^ADDR_W+1 words in fall-through mode. After that, `full` reads 1 and further writes are dropped without disturbing stored data.
- R4: In standard mode, `rd_stat_n` is 1 exactly when stored words are visible to the read side. A read strobe while it is 0 leaves `rd_data` unchanged.
- R5: In standard mode, a read strobe (`rd_en_n`=0) sampled with `rd_stat_n`=1 on a `rd_clk` rising edge places the next word on `rd_data` at that same edge.
- R6: In fall-through mode, whenever `rd_stat_n` is 0, `rd_data` already holds the oldest unread word. The flag falls at the edge where that word appears, and no read strobe is needed.
- R7: In fall-through mode, `rd_stat_n` rises only at a `rd_clk` edge with `rd_en_n`=0. After the last word is read, `rd_data` keeps that word, and further strobes have no effect until `rd_stat_n` is 0 again.
- R8: Once reads free space, `full` returns to 0 on a later `wr_clk` edge and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_mode | input | 1 | 0 = standard reads, 1 = fall-through reads; static outside reset |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | DATA_W | Write data |
| full | output | 1 | High when no room is left; synchronous to wr_clk |
| rd_en_n | input | 1 | Read strobe, active low |
| rd_data | output | DATA_W | Registered read data |
| rd_stat_n | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low, synchronous to rd_clk |

## Verification
The hardest state to reach from the ports is the fall-through boundary. There, the holding register has just been refilled by the same edge that consumed the previous word, and the array behind it is simultaneously full from the write side. The stimulus first lets a single word fall through. It then fills the array with back-to-back writes, so that the capacity of one extra word is measured exactly. After that, it runs skewed random phases (heavy writes with light reads, then the reverse) on clocks with unrelated periods, so that `full` and the ready flag toggle repeatedly while pointers are in flight. A scoreboard queue checks the bus contents on every read-side cycle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Gray conversion and ring distance on 32-bit carriers; callers truncate.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  function automatic logic [31:0] ring_dist(input logic [31:0] head,
                                            input logic [31:0] tail,
                                            input logic [31:0] mask);
    return (head - tail) & mask;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_n,
  input  logic [AW:0] rq2,
  output logic        full,
  output logic        wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] PMASK = (32'd1 << PW) - 32'd1;

  logic [AW:0] wbin_q, wbin_nxt, wgray_nxt, rq2_wrapped;
  logic        full_q;

  assign wr_fire     = !wr_en_n && !full_q;
  assign wbin_nxt    = wbin_q + {{AW{1'b0}}, wr_fire};
  assign wgray_nxt   = PW'(to_gray(32'(wbin_nxt)));
  assign rq2_wrapped = {~rq2[AW:AW-1], rq2[AW-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin_q <= wbin_nxt;
      wgray  <= wgray_nxt;
      full_q <= (wgray_nxt == rq2_wrapped);
    end
  end

  assign full  = full_q;
  assign waddr = wbin_q[AW-1:0];

  logic [31:0] wr_level;
  assign wr_level = ring_dist(32'(wbin_q), from_gray(32'(rq2)), PMASK);

  // R3
  wr_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level <= DEPTH);

  // R8
  notfull_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q |-> wr_level < DEPTH);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en_n,
  input  logic [AW:0]   wq2,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat_n
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] PMASK = (32'd1 << PW) - 32'd1;

  logic [AW:0]   rbin_q, rbin_nxt, rgray_nxt;
  logic          avail_q, avail_nxt;
  logic [DW-1:0] dout_q;

  // Named read-side events
  logic have_word;   // array holds words visible to this domain
  logic rd_take;     // accepted read strobe
  logic ho_load;     // holding register refilled (fall-through)
  logic step;        // array pointer advances

  assign have_word = (rgray != wq2);
  assign rd_take   = !rd_en_n && avail_q;
  assign ho_load   = have_word && (!avail_q || rd_take);
  assign step      = fwft ? ho_load : rd_take;
  assign rbin_nxt  = rbin_q + {{AW{1'b0}}, step};
  assign rgray_nxt = PW'(to_gray(32'(rbin_nxt)));

  always_comb begin
    if (!fwft) avail_nxt = (rgray_nxt != wq2);
    else if (ho_load) avail_nxt = 1'b1;
    else if (rd_take) avail_nxt = 1'b0;
    else avail_nxt = avail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray   <= '0;
      avail_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray   <= rgray_nxt;
      avail_q <= avail_nxt;
      if (step) dout_q <= mem_q;
    end
  end

  assign raddr     = rbin_q[AW-1:0];
  assign rd_data   = dout_q;
  assign rd_stat_n = fwft ? ~avail_q : avail_q;

  logic [31:0] rd_level;
  assign rd_level = ring_dist(from_gray(32'(wq2)), 32'(rbin_q), PMASK);

  // R2
  rd_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_level <= DEPTH);

  // R7
  fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwft && avail_q && rd_en_n |=> avail_q && $stable(dout_q));

  // R4
  std_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwft && !avail_q |=> $stable(dout_q));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              fwft_mode,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stat_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wq2, rq2;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire;
  logic [DATA_W-1:0] mem_q;

  dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(mrst_n), .wr_en_n(wr_en_n), .rq2(rq2),
    .full(full), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray)
  );

  dcf_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(mrst_n), .d(wgray), .q(wq2)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(mrst_n), .d(rgray), .q(rq2)
  );

  dcf_rd_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(mrst_n), .fwft(fwft_mode), .rd_en_n(rd_en_n),
    .wq2(wq2), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_stat_n(rd_stat_n)
  );
endmodule

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_fifo;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, mrst_n = 0, fwft = 0;
  logic wr_en_n = 1, rd_en_n = 1;
  logic [DW-1:0] wr_data = '0;
  wire full, rd_stat_n;
  wire [DW-1:0] rd_data;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .fwft_mode(fwft),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .full(full),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_stat_n(rd_stat_n)
  );

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  int wr_left = 0, wr_pct = 0, rd_pct = 0;
  bit chk_on = 0, prev_acc = 0, prev_try = 0, seen = 0;
  logic [DW-1:0] prev_exp = '0, last_out = '0;

  function automatic int capacity(input bit f);
    return f ? DEPTH + 1 : DEPTH;
  endfunction

  // expected level of the status pin given whether a word is available
  function automatic logic stat_level(input bit f, input bit avail);
    return f ? !avail : avail;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write driver
  initial forever begin
    @(negedge wr_clk);
    wr_en_n = 1;
    if (wr_left > 0) begin
      wr_left--;
      if ($urandom_range(99) < wr_pct) begin
        wr_en_n = 0;
        wr_data = DW'($urandom);
        if (!full) q.push_back(wr_data);
      end
    end
  end

  // read driver and per-cycle checker
  initial forever begin
    @(negedge rd_clk);
    if (chk_on) begin
      if (!fwft) begin
        if (prev_acc) check(rd_data == prev_exp, "R2 R5 std read data", rd_data, prev_exp);
        else if (prev_try) check(rd_data == last_out, "R4 blocked read kept data", rd_data, last_out);
        if (prev_acc) last_out = prev_exp;
      end else begin
        if (rd_stat_n == 1'b0) begin
          if (q.size() == 0) check(0, "R6 ready with nothing stored", rd_data, '0);
          else check(rd_data == q[0], "R2 R6 fall-through word", rd_data, q[0]);
        end else if (seen) check(rd_data == last_out, "R7 last word held", rd_data, last_out);
      end
    end
    prev_acc = 0; prev_try = 0; rd_en_n = 1;
    if ($urandom_range(99) < rd_pct) begin
      rd_en_n = 0; prev_try = 1;
      if (!fwft && rd_stat_n) begin
        if (q.size() > 0) begin prev_exp = q.pop_front(); prev_acc = 1; end
        else check(0, "R4 flag high with nothing stored", {17'b0, rd_stat_n}, '0);
      end
      if (fwft && !rd_stat_n && q.size() > 0) begin
        last_out = q.pop_front(); seen = 1;
      end
    end
  end

  task automatic do_reset(input bit mode);
    chk_on = 0; wr_left = 0; rd_pct = 0;
    repeat (3) @(negedge wr_clk);
    mrst_n = 0; fwft = mode;
    q.delete(); prev_acc = 0; prev_try = 0; seen = 0; last_out = '0;
    repeat (4) @(negedge rd_clk);
    check(full == 1'b0, "R1 full in reset", {17'b0, full}, '0);
    check(rd_stat_n == stat_level(mode, 0), "R1 status in reset",
          {17'b0, rd_stat_n}, {17'b0, stat_level(mode, 0)});
    mrst_n = 1;
    repeat (4) @(negedge rd_clk);
    check(rd_data == '0, "R1 data after reset", rd_data, '0);
    check(rd_stat_n == stat_level(mode, 0), "R1 status after reset",
          {17'b0, rd_stat_n}, {17'b0, stat_level(mode, 0)});
    chk_on = 1;
  endtask

  task automatic wait_wr();
    while (wr_left > 0) @(negedge wr_clk);
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic drain();
    rd_pct = 100;
    while (q.size() != 0) @(negedge rd_clk);
    repeat (8) @(negedge rd_clk);
    rd_pct = 0;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic fill_test(input bit mode);
    wr_pct = 100; wr_left = DEPTH + 3;
    wait_wr();
    repeat (12) @(negedge wr_clk);
    check(full == 1'b1, "R3 full after filling", {17'b0, full}, 18'd1);
    check(q.size() == capacity(mode), "R3 accepted word count",
          DW'(q.size()), DW'(capacity(mode)));
    drain();
    repeat (6) @(negedge wr_clk);
    check(full == 1'b0, "R8 full cleared after reads", {17'b0, full}, '0);
    check(rd_stat_n == stat_level(mode, 0), "R4 R7 status once emptied",
          {17'b0, rd_stat_n}, {17'b0, stat_level(mode, 0)});
  endtask

  task automatic random_phases();
    wr_pct = 90; rd_pct = 30; wr_left = 1200; wait_wr(); drain();
    wr_pct = 30; rd_pct = 90; wr_left = 1200; wait_wr(); drain();
    wr_pct = 55; rd_pct = 50; wr_left = 2000; wait_wr(); drain();
    check(q.size() == 0, "R2 all words delivered", DW'(q.size()), '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // standard mode
    do_reset(0);
    rd_pct = 100; repeat (10) @(negedge rd_clk); rd_pct = 0;
    repeat (2) @(negedge rd_clk);
    check(rd_stat_n == 1'b0, "R4 empty flag low", {17'b0, rd_stat_n}, '0);
    check(rd_data == '0, "R4 reads on empty ignored", rd_data, '0);
    fill_test(0);
    random_phases();

    // fall-through mode
    do_reset(1);
    wr_pct = 100; wr_left = 1; wait_wr();
    repeat (8) @(negedge rd_clk);
    check(rd_stat_n == 1'b0, "R6 ready without a read", {17'b0, rd_stat_n}, '0);
    check(q.size() == 1 && rd_data == q[0], "R6 first word on bus", rd_data, q[0]);
    fill_test(1);
    check(rd_data == last_out, "R7 last word stays", rd_data, last_out);
    rd_pct = 100; repeat (6) @(negedge rd_clk); rd_pct = 0;
    repeat (2) @(negedge rd_clk);
    check(rd_data == last_out && rd_stat_n == 1'b1, "R7 strobes while not ready",
          rd_data, last_out);
    random_phases();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge wr_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R2 progress) actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule